// File: doc/BRIEF.md
# Programmable Interval Timer with Interrupt

This block is a down-counting interval timer that a processor drives through four 16-bit registers on a simple memory-mapped bus. Software loads a 32-bit period as two 16-bit halves. It then writes a control word that sets the interrupt enable and the reload mode and starts the count. The counter runs from the period value down to zero. One cycle after it reaches zero it raises a timeout flag, and the interrupt line follows that flag while the enable is set.

In continuous mode the counter reloads the period after each zero and keeps going, so a period of P gives one timeout every P+1 clock cycles. For example, 49999 at a 50 MHz clock gives 1000 timeouts per second. In one-shot mode the counter stops after the first timeout. Software acknowledges a timeout by writing any value to the status register. Writing either period half stops the counter.

Top module: `interval_timer`

## Requirements
- R1: After reset the counter is stopped, the timeout flag and `irq` are 0, the control word reads 0x0000, and the period reads the parameter `RESET_PERIOD` (default 49999: low half 0xC34F, high half 0x0000).
- R2: Word offset 2 holds bits 15:0 of the period and offset 3 holds bits 31:16. Each half reads back the last value written to it.
- R3: A control write with bit 2 set loads the counter with the period and sets the running indication (status bit 1). With period P, the timeout flag is first seen after the (P+1)-th clock edge following the start write. The flag comes only from the count reaching zero.
- R4: When control bit 1 is 0 (one-shot), the counter stops after its first timeout. Status then reads 0x0001, and no further timeout occurs.
- R5: When control bit 1 is 1 (continuous), the counter reloads the period at zero, and timeouts recur every P+1 cycles.
- R6: `irq` is high exactly when the timeout flag (status bit 0) is set and control bit 0 is 1. Setting the enable while a timeout is pending raises `irq` at once.
- R7: A write of any value to status (offset 0) clears the timeout flag, and `irq` is low after that edge.
- R8: If a status write falls in the same cycle as a new timeout, the flag stays set, so the new event is not lost.
- R9: A write to either period half stops the counter (status bit 1 reads 0), and no timeout follows until the next start.
- R10: Control reads back bit 0 (interrupt enable) and bit 1 (continuous) as written. Bit 2 (start) and all higher bits read 0. Writing 0x0007 starts the timer with the interrupt enabled and continuous reload selected.
- R11: Read data appears on `bus_rdata` one clock after `bus_rd`. Word offsets 4 and above read 0x0000, and writes to them change no register and do not start the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W (3) | Word offset of the register accessed |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wdata | input | DATA_W (16) | Write data |
| bus_rdata | output | DATA_W (16) | Read data, registered |
| irq | output | 1 | Interrupt request: pending timeout and enable both set |

## Verification
Two events can fall in the same cycle: the counter setting the timeout flag at zero, and software clearing that flag with a status write. The bench runs a continuous count with a short period. It times a status write so that it lands on the exact edge of the next timeout. It then checks that `irq` is still high after that edge. A second status write one cycle later must bring `irq` low, which confirms that the first write was overridden by the timeout and was not simply ignored.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

   // Word offsets decoded by the register block
   typedef enum logic [1:0] {
      OFS_STATUS = 2'd0,
      OFS_CTRL   = 2'd1,
      OFS_PER_LO = 2'd2,
      OFS_PER_HI = 2'd3
   } reg_ofs_e;

   // Control word bit positions
   localparam int unsigned CTRL_IE   = 0;
   localparam int unsigned CTRL_CONT = 1;
   localparam int unsigned CTRL_GO   = 2;

   // Status word bit positions
   localparam int unsigned STAT_TMO = 0;
   localparam int unsigned STAT_RUN = 1;

   // Number of period halves
   localparam int unsigned PER_PARTS = 2;

endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
   import tmr_pkg::*;
#(
   parameter int unsigned ADDR_W = 3,
   parameter int unsigned DATA_W = 16,
   parameter int unsigned CNT_W  = 32,
   parameter logic [CNT_W-1:0] RESET_PERIOD = CNT_W'(49999)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wdata,
   output logic [CNT_W-1:0]  period,
   output logic              ie,
   output logic              cont,
   output logic              go,
   output logic              halt,
   output logic              clr
);

   logic               in_range;
   logic               wr_ok;
   reg_ofs_e           ofs;
   logic [DATA_W-1:0]  per_part [PER_PARTS];
   logic [PER_PARTS-1:0] per_hit;

   // Offsets above the four registers are outside the map
   generate
      if (ADDR_W > 2) begin : g_wide
         assign in_range = ~|addr[ADDR_W-1:2];
      end else begin : g_exact
         assign in_range = 1'b1;
      end
   endgenerate

   assign ofs   = reg_ofs_e'(addr[1:0]);
   assign wr_ok = wr_en & in_range;

   // One storage word for each period half
   generate
      for (genvar h = 0; h < PER_PARTS; h++) begin : g_part
         assign per_hit[h] = wr_ok & (ofs == reg_ofs_e'(OFS_PER_LO + h));
         always_ff @(posedge clk) begin
            if (!rst_n)
               per_part[h] <= RESET_PERIOD[h*DATA_W +: DATA_W];
            else if (per_hit[h])
               per_part[h] <= wdata;
         end
         assign period[h*DATA_W +: DATA_W] = per_part[h];
      end
   endgenerate

   // Control bits kept in storage
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ie   <= 1'b0;
         cont <= 1'b0;
      end else if (wr_ok && ofs == OFS_CTRL) begin
         ie   <= wdata[CTRL_IE];
         cont <= wdata[CTRL_CONT];
      end
   end

   // Single-cycle command strobes to the counter
   assign go   = wr_ok & (ofs == OFS_CTRL) & wdata[CTRL_GO];
   assign halt = |per_hit;
   assign clr  = wr_ok & (ofs == OFS_STATUS);

endmodule

// File: rtl/tmr_core.sv
module tmr_core #(
   parameter int unsigned CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] period,
   input  logic             cont,
   input  logic             go,
   input  logic             halt,
   input  logic             clr,
   output logic             zero_hit,
   output logic             flag,
   output logic             running
);

   logic [CNT_W-1:0] cnt;

   assign zero_hit = running & (cnt == '0);

   // Timeout flag: a new event outranks a clear in the same cycle
   always_ff @(posedge clk) begin
      if (!rst_n)
         flag <= 1'b0;
      else if (zero_hit)
         flag <= 1'b1;
      else if (clr)
         flag <= 1'b0;
   end

   // Down counter with reload or stop at zero
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt     <= '0;
         running <= 1'b0;
      end else if (halt) begin
         cnt     <= '0;
         running <= 1'b0;
      end else if (go) begin
         cnt     <= period;
         running <= 1'b1;
      end else if (running) begin
         if (cnt == '0) begin
            if (cont)
               cnt <= period;
            else
               running <= 1'b0;
         end else begin
            cnt <= cnt - 1'b1;
         end
      end
   end

endmodule

// File: rtl/tmr_rdmux.sv
module tmr_rdmux
   import tmr_pkg::*;
#(
   parameter int unsigned ADDR_W = 3,
   parameter int unsigned DATA_W = 16,
   parameter int unsigned CNT_W  = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              rd_en,
   input  logic              flag,
   input  logic              running,
   input  logic              ie,
   input  logic              cont,
   input  logic [CNT_W-1:0]  period,
   output logic [DATA_W-1:0] rdata
);

   logic              in_range;
   logic [DATA_W-1:0] stat_w;
   logic [DATA_W-1:0] ctrl_w;
   logic [DATA_W-1:0] sel_w;

   generate
      if (ADDR_W > 2) begin : g_wide
         assign in_range = ~|addr[ADDR_W-1:2];
      end else begin : g_exact
         assign in_range = 1'b1;
      end
   endgenerate

   always_comb begin
      stat_w           = '0;
      stat_w[STAT_TMO] = flag;
      stat_w[STAT_RUN] = running;
      ctrl_w            = '0;
      ctrl_w[CTRL_IE]   = ie;
      ctrl_w[CTRL_CONT] = cont;
   end

   always_comb begin
      sel_w = '0;
      if (in_range) begin
         unique case (reg_ofs_e'(addr[1:0]))
            OFS_STATUS: sel_w = stat_w;
            OFS_CTRL:   sel_w = ctrl_w;
            OFS_PER_LO: sel_w = period[DATA_W-1:0];
            OFS_PER_HI: sel_w = period[CNT_W-1:DATA_W];
            default:    sel_w = '0;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         rdata <= '0;
      else if (rd_en)
         rdata <= sel_w;
   end

endmodule

// File: rtl/interval_timer.sv
module interval_timer #(
   parameter int unsigned ADDR_W = 3,
   parameter int unsigned DATA_W = 16,
   parameter int unsigned CNT_W  = 32,
   parameter logic [CNT_W-1:0] RESET_PERIOD = CNT_W'(49999)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq
);

   // Elaboration-time parameter checks
   generate
      if (CNT_W != 2 * DATA_W) begin : g_bad_cnt
         $error("interval_timer: CNT_W must be twice DATA_W");
      end
      if (DATA_W < 3) begin : g_bad_data
         $error("interval_timer: DATA_W must hold the control bits");
      end
      if (ADDR_W < 2) begin : g_bad_addr
         $error("interval_timer: ADDR_W must cover four registers");
      end
   endgenerate

   logic [CNT_W-1:0] period;
   logic             ie;
   logic             cont;
   logic             go;
   logic             halt;
   logic             clr;
   logic             zero_hit;
   logic             tmo_flag;
   logic             running;

   tmr_regs #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .RESET_PERIOD(RESET_PERIOD)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wr_en(bus_wr), .wdata(bus_wdata),
      .period(period), .ie(ie), .cont(cont), .go(go), .halt(halt), .clr(clr)
   );

   tmr_core #(.CNT_W(CNT_W)) u_core (
      .clk(clk), .rst_n(rst_n), .period(period), .cont(cont), .go(go),
      .halt(halt), .clr(clr), .zero_hit(zero_hit), .flag(tmo_flag), .running(running)
   );

   tmr_rdmux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_rd (
      .clk(clk), .rst_n(rst_n), .addr(bus_addr), .rd_en(bus_rd), .flag(tmo_flag),
      .running(running), .ie(ie), .cont(cont), .period(period), .rdata(bus_rdata)
   );

   assign irq = tmo_flag & ie;

endmodule

// File: rtl/interval_timer_chk.sv
module interval_timer_chk #(
   parameter int unsigned ADDR_W = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_wr,
   input logic              zero_hit,
   input logic              tmo_flag,
   input logic              running,
   input logic              cont,
   input logic              go,
   input logic              halt
);

   // R8: a timeout always leaves the flag set, even against a clear
   a_r8_timeout_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
      zero_hit |=> tmo_flag);

   // R7: a status write with no coinciding timeout clears the flag
   a_r7_clear_drops_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == '0 && !zero_hit) |=> !tmo_flag);

   // R4: one-shot mode stops after the timeout
   a_r4_oneshot_halts: assert property (@(posedge clk) disable iff (!rst_n)
      (zero_hit && !cont && !go && !halt) |=> !running);

   // R5: continuous mode keeps counting after the timeout
   a_r5_cont_keeps_running: assert property (@(posedge clk) disable iff (!rst_n)
      (zero_hit && cont && !halt) |=> running);

   // R9: a period write stops the counter
   a_r9_period_write_stops: assert property (@(posedge clk) disable iff (!rst_n)
      halt |=> !running);

   // R3: the flag rises only on the count reaching zero
   a_r3_flag_only_from_zero: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tmo_flag) |-> $past(zero_hit));

endmodule

bind interval_timer interval_timer_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
   .zero_hit(zero_hit), .tmo_flag(tmo_flag), .running(running),
   .cont(cont), .go(go), .halt(halt)
);

// File: tb/interval_timer_test.sv
module interval_timer_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic        irq;

   int n_chk = 0;
   int n_bad = 0;

   always #4 clk = ~clk;   // 125 MHz

   interval_timer uut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   // Called at a falling edge; the write lands on the next rising edge
   task automatic wr(input logic [2:0] a, input logic [15:0] d);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [15:0] d);
      bus_addr = a; bus_rd = 1'b1;
      @(negedge clk);
      bus_rd = 1'b0;
      d = bus_rdata;
   endtask

   task automatic t_reset();
      logic [15:0] d;
      chk("R1 irq", irq, 0);
      rd(0, d); chk("R1 status", d, 16'h0000);
      rd(1, d); chk("R1 control", d, 16'h0000);
      rd(2, d); chk("R1 period low", d, 16'hC34F);
      rd(3, d); chk("R1 period high", d, 16'h0000);
   endtask

   task automatic t_halves();
      logic [15:0] d;
      wr(2, 16'h1234); wr(3, 16'hABCD);
      rd(2, d); chk("R2 low half", d, 16'h1234);
      rd(3, d); chk("R2 high half", d, 16'hABCD);
   endtask

   task automatic t_oneshot();
      logic [15:0] d;
      wr(2, 16'd5); wr(3, 16'd0);
      wr(1, 16'h0005);               // enable + start, one-shot
      repeat (5) @(negedge clk);
      chk("R3 no timeout before P+1", irq, 0);
      @(negedge clk);
      chk("R3 timeout at P+1", irq, 1);
      rd(0, d); chk("R4 stopped with flag", d, 16'h0001);
      wr(0, 16'h0000);
      chk("R7 clear drops irq", irq, 0);
      repeat (20) @(negedge clk);
      chk("R4 no second timeout", irq, 0);
   endtask

   task automatic t_halt();
      logic [15:0] d;
      wr(2, 16'd1000); wr(3, 16'd0);
      wr(1, 16'h0004);               // start only
      rd(0, d); chk("R3 running indication", d, 16'h0002);
      wr(2, 16'd1000);
      rd(0, d); chk("R9 period write stops", d, 16'h0000);
      repeat (1100) @(negedge clk);
      rd(0, d); chk("R9 no timeout after stop", d, 16'h0000);
   endtask

   task automatic t_continuous();
      logic [15:0] d;
      wr(2, 16'd9); wr(3, 16'd0);
      wr(1, 16'h0007);               // after edge E0
      repeat (9) @(negedge clk);
      chk("R5 before first timeout", irq, 0);
      @(negedge clk);                // after E10
      chk("R5 first timeout", irq, 1);
      wr(0, 16'h0000);               // clear at E11
      repeat (8) @(negedge clk);     // after E19
      chk("R5 before reload timeout", irq, 0);
      @(negedge clk);                // after E20
      chk("R5 reload timeout", irq, 1);
      repeat (9) @(negedge clk);     // after E29
      wr(0, 16'h0000);               // clear lands on E30 timeout
      chk("R8 timeout beats clear", irq, 1);
      wr(0, 16'h0000);               // clear at E31
      chk("R7 clear after coincidence", irq, 0);
      rd(1, d); chk("R10 control readback", d, 16'h0003);
   endtask

   task automatic t_enable();
      logic [15:0] d;
      wr(1, 16'h0002);               // enable off, still continuous
      repeat (12) @(negedge clk);
      chk("R6 masked irq", irq, 0);
      rd(0, d); chk("R6 flag pending", {31'd0, d[0]}, 1);
      wr(1, 16'h0003);
      chk("R6 enable raises irq", irq, 1);
      wr(2, 16'd9);
      wr(0, 16'h0000);
      chk("R7 cleared after stop", irq, 0);
   endtask

   task automatic t_outside();
      logic [15:0] d;
      wr(5, 16'hFFFF);
      rd(1, d); chk("R11 control unchanged", d, 16'h0003);
      rd(2, d); chk("R11 period unchanged", d, 16'd9);
      rd(0, d); chk("R11 not started", d, 16'h0000);
      rd(6, d); chk("R11 outside reads zero", d, 16'h0000);
      repeat (30) @(negedge clk);
      chk("R11 no timeout", irq, 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_halves();
      t_oneshot();
      t_halt();
      t_continuous();
      t_enable();
      t_outside();
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

endmodule